// File: doc/BRIEF.md
# Register-Programmed Block Copy Engine

This block moves a run of bytes from one place in a 20-bit byte-addressed memory space to another. Software fills in a source address, a destination address and a byte count through a small byte-wide register port. It then writes the control register with its top bit set. The engine reads one byte from the source, writes it to the destination, steps both addresses up by one, and repeats until the count is used up. Every access goes over a plain request/acknowledge memory port.

When the run finishes, the engine leaves the registers in a state that software can use to continue or to confirm the copy. The byte count reads zero. The control register reads zero. The low 16 bits of each address register hold the address just past the last byte moved. A `busy` output is high for the whole transfer, so that surrounding logic can keep other bus masters off the memory. Register writes made while the engine is busy are dropped.

Top module: `blkdma_top`

## Requirements
- R1: Register indices on `reg_addr` are as follows. 0, 1 and 2 are the source address bits 7:0, 15:8 and 19:16. 3, 4 and 5 are the destination address in the same arrangement. 6 and 7 are the byte count bits 7:0 and 15:8. 8 is the control byte. When idle, a write is read back unchanged on `reg_rdata`, which follows `reg_addr` combinationally. Indices 2 and 5 keep only data bits 3:0 and read bits 7:4 as 0. All other indices read 0.
- R2: When idle, writing index 8 with bit 7 set and a nonzero count starts a transfer, and `busy` is high from the next clock edge. Writing index 8 with bit 7 clear only stores the byte.
- R3: For each byte, the engine reads at the current source address and then writes the byte it read to the current destination address. Both addresses then increase by one, wrapping modulo 2^20. A count of N moves exactly N bytes.
- R4: An access holds `mem_req` high, with `mem_addr` and `mem_we` unchanged, until `mem_ack` is high at a clock edge. Each read (`mem_we`=0) is followed directly by its write (`mem_we`=1).
- R5: When the last write is acknowledged, `busy` drops at the next edge. At that edge the count registers (indices 6 and 7) and the control register (index 8) become 0.
- R6: At completion, indices 0 and 1 together hold (start source + N) mod 2^16, and indices 3 and 4 hold (start destination + N) mod 2^16. Indices 2 and 5 keep the values they held at the start.
- R7: A start with a count of 0 makes no memory access and never raises `busy`, and index 8 reads 0 after the write.
- R8: While `busy` is high, all register writes are ignored, including writes to index 8. The transfer and the final register values are unaffected.
- R9: `mem_req` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Memory access acknowledge |

## Verification
A wrong working address or data latch shows up on `mem_addr` or `mem_wdata` at the very access it corrupts, so the scoreboard catches it within one handshake. A wrong remaining-count value shows only at the end of the run: `busy` drops one byte early or late, or never drops, and the scoreboard sees a missing or extra access. A bad write-back of the address, count or control registers does not show until those registers are read after `busy` falls. Each run therefore ends with a full register readback, including runs whose addresses carry across bit 15 and wrap past bit 19.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  localparam int ADDR_W = 20;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int RIDX_W = 4;
  localparam int HI_W   = ADDR_W - 16;
  localparam int GO_BIT = 7;

  localparam logic [RIDX_W-1:0] IX_SRC_LO  = 4'd0;
  localparam logic [RIDX_W-1:0] IX_SRC_MID = 4'd1;
  localparam logic [RIDX_W-1:0] IX_SRC_HI  = 4'd2;
  localparam logic [RIDX_W-1:0] IX_DST_LO  = 4'd3;
  localparam logic [RIDX_W-1:0] IX_DST_MID = 4'd4;
  localparam logic [RIDX_W-1:0] IX_DST_HI  = 4'd5;
  localparam logic [RIDX_W-1:0] IX_CNT_LO  = 4'd6;
  localparam logic [RIDX_W-1:0] IX_CNT_HI  = 4'd7;
  localparam logic [RIDX_W-1:0] IX_CTRL    = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_state_t;
endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
  import blkdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [15:0]       fin_src,
  input  logic [15:0]       fin_dst,
  output logic              go,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  xfer_cnt
);
  logic [BYTE_W-1:0] src_q [2];
  logic [BYTE_W-1:0] src_d [2];
  logic [BYTE_W-1:0] dst_q [2];
  logic [BYTE_W-1:0] dst_d [2];
  logic [BYTE_W-1:0] cnt_q [2];
  logic [BYTE_W-1:0] cnt_d [2];
  logic [HI_W-1:0]   src_hi_q, src_hi_d, dst_hi_q, dst_hi_d;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic              wr_ok, start_req, cnt_zero;

  assign src_addr  = {src_hi_q, src_q[1], src_q[0]};
  assign dst_addr  = {dst_hi_q, dst_q[1], dst_q[0]};
  assign xfer_cnt  = {cnt_q[1], cnt_q[0]};
  assign cnt_zero  = (xfer_cnt == '0);
  assign wr_ok     = reg_we && !busy;
  assign start_req = wr_ok && (reg_addr == IX_CTRL) && reg_wdata[GO_BIT];
  assign go        = start_req && !cnt_zero;

  always_comb begin
    src_d    = src_q;
    dst_d    = dst_q;
    cnt_d    = cnt_q;
    src_hi_d = src_hi_q;
    dst_hi_d = dst_hi_q;
    ctrl_d   = ctrl_q;
    if (done) begin
      src_d[0] = fin_src[7:0];
      src_d[1] = fin_src[15:8];
      dst_d[0] = fin_dst[7:0];
      dst_d[1] = fin_dst[15:8];
      cnt_d[0] = '0;
      cnt_d[1] = '0;
      ctrl_d   = '0;
    end else if (wr_ok) begin
      case (reg_addr)
        IX_SRC_LO:  src_d[0] = reg_wdata;
        IX_SRC_MID: src_d[1] = reg_wdata;
        IX_SRC_HI:  src_hi_d = reg_wdata[HI_W-1:0];
        IX_DST_LO:  dst_d[0] = reg_wdata;
        IX_DST_MID: dst_d[1] = reg_wdata;
        IX_DST_HI:  dst_hi_d = reg_wdata[HI_W-1:0];
        IX_CNT_LO:  cnt_d[0] = reg_wdata;
        IX_CNT_HI:  cnt_d[1] = reg_wdata;
        IX_CTRL:    ctrl_d   = (start_req && cnt_zero) ? '0 : reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      IX_SRC_LO:  reg_rdata = src_q[0];
      IX_SRC_MID: reg_rdata = src_q[1];
      IX_SRC_HI:  reg_rdata = BYTE_W'(src_hi_q);
      IX_DST_LO:  reg_rdata = dst_q[0];
      IX_DST_MID: reg_rdata = dst_q[1];
      IX_DST_HI:  reg_rdata = BYTE_W'(dst_hi_q);
      IX_CNT_LO:  reg_rdata = cnt_q[0];
      IX_CNT_HI:  reg_rdata = cnt_q[1];
      IX_CTRL:    reg_rdata = ctrl_q;
      default:    reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      src_hi_q <= '0;
      dst_hi_q <= '0;
      ctrl_q   <= '0;
    end else begin
      src_q    <= src_d;
      dst_q    <= dst_d;
      cnt_q    <= cnt_d;
      src_hi_q <= src_hi_d;
      dst_hi_q <= dst_hi_d;
      ctrl_q   <= ctrl_d;
    end
  end
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
  import blkdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [CNT_W-1:0]  xfer_cnt,
  output logic              busy,
  output logic              done,
  output logic [15:0]       fin_src,
  output logic [15:0]       fin_dst,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  eng_state_t        state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [BYTE_W-1:0] data_q, data_d;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    data_d  = data_q;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        src_d   = src_addr;
        dst_d   = dst_addr;
        rem_d   = xfer_cnt;
        state_d = ST_READ;
      end
      ST_READ: if (mem_ack) begin
        data_d  = mem_rdata;
        state_d = ST_WRITE;
      end
      ST_WRITE: if (mem_ack) begin
        src_d = src_q + ADDR_W'(1);
        dst_d = dst_q + ADDR_W'(1);
        rem_d = rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) begin
          state_d = ST_IDLE;
          done    = 1'b1;
        end else begin
          state_d = ST_READ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign fin_src   = src_q[15:0] + 16'd1;
  assign fin_dst   = dst_q[15:0] + 16'd1;
  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = mem_we ? dst_q : src_q;
  assign mem_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      rem_q   <= rem_d;
      data_q  <= data_d;
    end
  end
endmodule

// File: rtl/blkdma_top.sv
module blkdma_top
  import blkdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic              rst_meta, rst_sync;
  logic              go, done;
  logic [15:0]       fin_src, fin_dst;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [CNT_W-1:0]  xfer_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  blkdma_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (busy),
    .done     (done),
    .fin_src  (fin_src),
    .fin_dst  (fin_dst),
    .go       (go),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .xfer_cnt (xfer_cnt)
  );

  blkdma_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_sync),
    .go       (go),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .xfer_cnt (xfer_cnt),
    .busy     (busy),
    .done     (done),
    .fin_src  (fin_src),
    .fin_dst  (fin_dst),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .mem_ack  (mem_ack)
  );
endmodule

// File: rtl/blkdma_checks.sv
module blkdma_checks
  import blkdma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [RIDX_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              busy,
  input logic              go,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> (mem_req && mem_we));

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_ctrl_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && reg_addr == IX_CTRL) |-> (reg_rdata == '0));

  p_zero_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && reg_addr == IX_CTRL && reg_wdata[GO_BIT] && !go) |=> !busy);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind blkdma_top blkdma_checks u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .busy     (busy),
  .go       (go),
  .done     (done),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack)
);

// File: tb/test_blkdma_top.sv
module test_blkdma_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        busy, mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  typedef struct packed { logic we; logic [19:0] addr; logic [7:0] data; } acc_t;
  acc_t exp_q[$];

  always #2 clk = ~clk;

  blkdma_top i_blkdma_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [7:0] src_byte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  logic [2:0] wait_cnt = '0;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= {1'b0, mem_addr[1:0]}) begin
        wait_cnt = '0;
        mem_ack = 1'b1;
        if (!mem_we) mem_rdata = src_byte(mem_addr);
        if (exp_q.size() == 0) begin
          check("R3 unexpected access", {11'd0, mem_we, mem_addr}, 32'hFFFFFFFF);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          check("R4 access kind", {31'd0, mem_we}, {31'd0, e.we});
          check("R3 access address", {12'd0, mem_addr}, {12'd0, e.addr});
          if (mem_we) check("R3 write data", {24'd0, mem_wdata}, {24'd0, e.data});
        end
      end else begin
        wait_cnt = wait_cnt + 3'd1;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic load(input logic [19:0] s, input logic [19:0] t, input logic [15:0] n);
    wr(4'd0, s[7:0]); wr(4'd1, s[15:8]); wr(4'd2, {4'd0, s[19:16]});
    wr(4'd3, t[7:0]); wr(4'd4, t[15:8]); wr(4'd5, {4'd0, t[19:16]});
    wr(4'd6, n[7:0]); wr(4'd7, n[15:8]);
    for (int i = 0; i < int'(n); i++) begin
      logic [19:0] sa, da;
      sa = s + 20'(i);
      da = t + 20'(i);
      exp_q.push_back('{we: 1'b0, addr: sa, data: 8'h00});
      exp_q.push_back('{we: 1'b1, addr: da, data: src_byte(sa)});
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic final_regs(input logic [19:0] s, input logic [19:0] t, input logic [15:0] n);
    logic [7:0] v;
    logic [15:0] fs, fd;
    fs = s[15:0] + n;
    fd = t[15:0] + n;
    check("R3 all accesses seen", exp_q.size(), 0);
    rd(4'd6, v); check("R5 count low cleared", v, 0);
    rd(4'd7, v); check("R5 count high cleared", v, 0);
    rd(4'd8, v); check("R5 control cleared", v, 0);
    rd(4'd0, v); check("R6 source low", v, fs[7:0]);
    rd(4'd1, v); check("R6 source mid", v, fs[15:8]);
    rd(4'd2, v); check("R6 source high kept", v, s[19:16]);
    rd(4'd3, v); check("R6 dest low", v, fd[7:0]);
    rd(4'd4, v); check("R6 dest mid", v, fd[15:8]);
    rd(4'd5, v); check("R6 dest high kept", v, t[19:16]);
  endtask

  task automatic copy(input logic [19:0] s, input logic [19:0] t, input logic [15:0] n);
    load(s, t, n);
    wr(4'd8, 8'h80);
    check("R2 busy after start", busy, 1);
    wait_idle();
    check("R5 busy dropped", busy, 0);
    final_regs(s, t, n);
  endtask

  initial begin
    #(4 * 200000);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R9 idle no request", mem_req, 0);
    check("R2 idle after reset", busy, 0);
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), v);
      check("R1 reset value", v, 0);
    end

    // R1 readback
    wr(4'd0, 8'hA5); rd(4'd0, v); check("R1 source low", v, 8'hA5);
    wr(4'd4, 8'h3C); rd(4'd4, v); check("R1 dest mid", v, 8'h3C);
    wr(4'd2, 8'hFF); rd(4'd2, v); check("R1 high nibble only", v, 8'h0F);
    wr(4'd7, 8'h12); rd(4'd7, v); check("R1 count high", v, 8'h12);
    wr(4'd9, 8'h77); rd(4'd9, v); check("R1 unmapped reads zero", v, 0);

    // R2: control write without start bit only stores
    wr(4'd8, 8'h05);
    check("R2 no start without bit 7", busy, 0);
    rd(4'd8, v); check("R2 control stored", v, 8'h05);
    repeat (3) @(negedge clk);
    check("R9 still idle", mem_req, 0);

    // main copies
    copy(20'h12340, 20'h56780, 16'd5);
    copy(20'h2FFFE, 20'hFFFFD, 16'd4);
    copy(20'h00101, 20'h80000, 16'd1);

    // R7 zero count
    load(20'h11111, 20'h22222, 16'd0);
    wr(4'd8, 8'h80);
    check("R7 busy stays low", busy, 0);
    rd(4'd8, v); check("R7 control reads zero", v, 0);
    repeat (6) @(negedge clk);
    check("R7 no request", mem_req, 0);
    check("R7 busy still low", busy, 0);

    // R8 writes ignored while busy
    load(20'h0ABCD, 20'h01000, 16'd3);
    wr(4'd8, 8'h80);
    check("R2 busy for R8 run", busy, 1);
    wr(4'd0, 8'hEE);
    wr(4'd6, 8'h00);
    wr(4'd2, 8'h09);
    wr(4'd8, 8'h00);
    check("R8 busy kept through writes", busy, 1);
    wait_idle();
    check("R8 busy dropped", busy, 0);
    final_regs(20'h0ABCD, 20'h01000, 16'd3);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule